// File: doc/BRIEF.md
# FIFO Almost-Empty / Almost-Full Offset Loader

This block holds the two programmable threshold offsets of a FIFO: the almost-empty offset and the almost-full offset. One shared set of active-low enables either reaches the FIFO memory or reaches these offset registers. A single select line chooses between the two. The memory array and the flag comparators that use the offsets are outside the block. The block itself drives only the two offset values, the read-back data and the memory write and read strobes.

The offsets can be loaded in one of two ways. In the first, the data bus writes them one half at a time in a fixed four-step sequence. In the second, a serial chain shifts them in one bit per write clock. The load method is sampled from a mode pin during master reset and stays fixed until the next master reset. Parallel read-back follows the same four-step sequence on the read clock and is allowed under either load method.

Two copies of a small sequencer track the position in the four-step sequence, one for writes and one for reads. Each has the states STEP_EMP_LO, STEP_EMP_HI, STEP_FUL_LO and STEP_FUL_HI. An advance moves it to the next state in that order, and STEP_FUL_HI wraps to STEP_EMP_LO. With no advance the sequencer holds its state. Master reset returns it to STEP_EMP_LO.

Top module: `offset_loader_top`

## Requirements
- R1: During master reset (mrst_n low on a clock edge), the almost-empty offset loads DEF_AE (default 16'h0007), the almost-full offset loads DEF_AF (default 16'h003F), rb_data loads 0, and both sequencers return to STEP_EMP_LO.
- R2: With mem_sel high, mem_wr equals the inverse of wen_n and mem_rd equals the inverse of ren_n, and both may be high together. No offset register changes.
- R3: With mem_sel low, wen_n low, ren_n high and parallel mode, each wclk edge writes din[HALF-1:0] into one offset half. The order is empty low, empty high, full low, full high, where HALF is OFS_W/2.
- R4: After the fourth parallel write, the write sequencer wraps, and the fifth write lands in the empty-offset low half again.
- R5: With mem_sel low, wen_n high and ren_n low, each rclk edge loads rb_data with one offset half, zero-extended, in the same four-step order with wrap. This works in both load modes.
- R6: With mem_sel low, wen_n and ren_n high, sen_n low and serial mode, each wclk edge shifts sdin into a chain of 2*OFS_W bits. After 2*OFS_W shifts, the first bit sits at bit 0 of the empty offset and the last bit at the top bit of the full offset.
- R7: The load mode is sampled from load_mode (1 = serial, 0 = parallel) only during master reset. Changes on load_mode afterwards have no effect.
- R8: A parallel write in serial mode changes no register and does not advance the write sequencer. A serial shift in parallel mode changes no register.
- R9: Each sequencer holds its position while mem_sel is high, and also when no register access is decoded. With mem_sel low, wen_n and ren_n both low is a no-operation.
- R10: With mem_sel low, mem_wr and mem_rd stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; offset storage and write sequencer |
| rclk | input | 1 | Read clock; read-back sequencer and rb_data |
| mrst_n | input | 1 | Synchronous master reset, active low |
| load_mode | input | 1 | Load method sampled during reset: 1 serial, 0 parallel |
| mem_sel | input | 1 | 1 = memory access, 0 = offset register access |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| din | input | BUS_W | Parallel write data |
| sdin | input | 1 | Serial data bit |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| rb_data | output | BUS_W | Parallel read-back data |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |

## Verification
Memory write and memory read can fall in the same cycle. The bench provokes this by holding mem_sel high with both enables low. It expects both strobes to be high at once and both offsets to stay unchanged across the edge. With mem_sel low, the same enable pair would ask for a register write and a read-back in the same cycle. The bench drives exactly that and expects a no-operation. It judges the result at the ports: the next parallel write must land in the half that follows the last real write, and the offsets must be unchanged.

// File: rtl/offset_pkg.sv
package offset_pkg;
    typedef enum logic [1:0] {
        STEP_EMP_LO = 2'd0,
        STEP_EMP_HI = 2'd1,
        STEP_FUL_LO = 2'd2,
        STEP_FUL_HI = 2'd3
    } step_t;
endpackage

// File: rtl/offset_step_seq.sv
module offset_step_seq
    import offset_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    output step_t step
);
    step_t step_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) step <= STEP_EMP_LO;
        else        step <= step_nxt;
    end

    always_comb begin
        step_nxt = step;
        if (advance) begin
            unique case (step)
                STEP_EMP_LO: step_nxt = STEP_EMP_HI;
                STEP_EMP_HI: step_nxt = STEP_FUL_LO;
                STEP_FUL_LO: step_nxt = STEP_FUL_HI;
                STEP_FUL_HI: step_nxt = STEP_EMP_LO;
            endcase
        end
    end

    // R9
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(step));
    // R4
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && step == STEP_FUL_HI) |=> step == STEP_EMP_LO);
endmodule

// File: rtl/offset_store.sv
module offset_store
    import offset_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int BUS_W = 9,
    parameter logic [OFS_W-1:0] DEF_AE = 16'h0007,
    parameter logic [OFS_W-1:0] DEF_AF = 16'h003F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic             wr_go,
    input  logic             shift_go,
    input  step_t            wr_step,
    input  logic [BUS_W-1:0] din,
    input  logic             sdin,
    output logic [OFS_W-1:0] ae,
    output logic [OFS_W-1:0] af,
    output logic             serial_mode
);
    localparam int HALF = OFS_W / 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_mode <= mode_in;
            ae          <= DEF_AE;
            af          <= DEF_AF;
        end else if (wr_go) begin
            unique case (wr_step)
                STEP_EMP_LO: ae[HALF-1:0]     <= din[HALF-1:0];
                STEP_EMP_HI: ae[OFS_W-1:HALF] <= din[HALF-1:0];
                STEP_FUL_LO: af[HALF-1:0]     <= din[HALF-1:0];
                STEP_FUL_HI: af[OFS_W-1:HALF] <= din[HALF-1:0];
            endcase
        end else if (shift_go) begin
            {af, ae} <= {sdin, af, ae[OFS_W-1:1]};
        end
    end

    // R7
    mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(serial_mode));
    // R6
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_go |=> af[OFS_W-1] == $past(sdin));
endmodule

// File: rtl/offset_readback.sv
module offset_readback
    import offset_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int BUS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_go,
    input  step_t            rd_step,
    input  logic [OFS_W-1:0] ae,
    input  logic [OFS_W-1:0] af,
    output logic [BUS_W-1:0] rb_data
);
    localparam int HALF = OFS_W / 2;
    logic [HALF-1:0] half_sel;

    always_comb begin
        unique case (rd_step)
            STEP_EMP_LO: half_sel = ae[HALF-1:0];
            STEP_EMP_HI: half_sel = ae[OFS_W-1:HALF];
            STEP_FUL_LO: half_sel = af[HALF-1:0];
            STEP_FUL_HI: half_sel = af[OFS_W-1:HALF];
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rb_data <= '0;
        else if (rd_go) rb_data <= BUS_W'(half_sel);
    end

    // R5
    rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rb_data));
endmodule

// File: rtl/offset_loader_top.sv
module offset_loader_top
    import offset_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int BUS_W = 9,
    parameter logic [OFS_W-1:0] DEF_AE = 16'h0007,
    parameter logic [OFS_W-1:0] DEF_AF = 16'h003F
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mrst_n,
    input  logic             load_mode,
    input  logic             mem_sel,
    input  logic             wen_n,
    input  logic             ren_n,
    input  logic             sen_n,
    input  logic [BUS_W-1:0] din,
    input  logic             sdin,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs,
    output logic [BUS_W-1:0] rb_data,
    output logic             mem_wr,
    output logic             mem_rd
);
    logic  serial_mode;
    logic  reg_acc, par_req, wr_go, rd_go, shift_go;
    step_t wr_step, rd_step;

    assign reg_acc  = !mem_sel;
    assign par_req  = reg_acc && !wen_n && ren_n;
    assign wr_go    = par_req && !serial_mode;
    assign rd_go    = reg_acc && wen_n && !ren_n;
    assign shift_go = reg_acc && wen_n && ren_n && !sen_n && serial_mode;
    assign mem_wr   = mem_sel && !wen_n;
    assign mem_rd   = mem_sel && !ren_n;

    offset_step_seq u_wr_seq (.clk(wclk), .rst_n(mrst_n), .advance(wr_go), .step(wr_step));
    offset_step_seq u_rd_seq (.clk(rclk), .rst_n(mrst_n), .advance(rd_go), .step(rd_step));

    offset_store #(.OFS_W(OFS_W), .BUS_W(BUS_W), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_store (
        .clk(wclk), .rst_n(mrst_n), .mode_in(load_mode), .wr_go(wr_go),
        .shift_go(shift_go), .wr_step(wr_step), .din(din), .sdin(sdin),
        .ae(ae_ofs), .af(af_ofs), .serial_mode(serial_mode)
    );

    offset_readback #(.OFS_W(OFS_W), .BUS_W(BUS_W)) u_rb (
        .clk(rclk), .rst_n(mrst_n), .rd_go(rd_go), .rd_step(rd_step),
        .ae(ae_ofs), .af(af_ofs), .rb_data(rb_data)
    );

    // R2
    mem_quiet_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        mem_sel |=> ($stable(ae_ofs) && $stable(af_ofs)));
    // R8
    serial_blocks_par_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (par_req && serial_mode) |=> ($stable(ae_ofs) && $stable(af_ofs)));
    // R10
    strobes_off_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !mem_sel |-> !(mem_wr || mem_rd));
endmodule

// File: tb/offset_loader_top_test.sv
module offset_loader_top_test;
    logic clk = 1'b0;
    logic mrst_n = 1'b0, load_mode = 1'b0, mem_sel = 1'b1;
    logic wen_n = 1'b1, ren_n = 1'b1, sen_n = 1'b1, sdin = 1'b0;
    logic [8:0]  din = '0;
    logic [15:0] ae_ofs, af_ofs;
    logic [8:0]  rb_data;
    logic        mem_wr, mem_rd;
    int errors = 0, checks = 0;

    always #2.5 clk = ~clk;

    offset_loader_top uut (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .load_mode(load_mode),
        .mem_sel(mem_sel), .wen_n(wen_n), .ren_n(ren_n), .sen_n(sen_n),
        .din(din), .sdin(sdin), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .rb_data(rb_data), .mem_wr(mem_wr), .mem_rd(mem_rd)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        mem_sel = 1'b1; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b1;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        idle(); mrst_n = 1'b0; load_mode = mode;
        @(negedge clk); @(negedge clk);
        mrst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [8:0] d);
        mem_sel = 1'b0; wen_n = 1'b0; ren_n = 1'b1; din = d;
        @(negedge clk); idle();
    endtask

    task automatic reg_read();
        mem_sel = 1'b0; wen_n = 1'b1; ren_n = 1'b0;
        @(negedge clk); idle();
    endtask

    task automatic shift_bit(input logic b);
        mem_sel = 1'b0; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b0; sdin = b;
        @(negedge clk); idle();
    endtask

    task automatic test_reset();
        do_reset(1'b0);
        chk(ae_ofs == 16'h0007, "R1 ae default", ae_ofs, 16'h0007);
        chk(af_ofs == 16'h003F, "R1 af default", af_ofs, 16'h003F);
        chk(rb_data == 9'h0, "R1 rb_data", rb_data, 0);
        chk(!mem_wr && !mem_rd, "R1 strobes", {mem_wr, mem_rd}, 0);
    endtask

    task automatic test_par_write();
        reg_write(9'h1A1); reg_write(9'h0B2); reg_write(9'h1C3); reg_write(9'h0D4);
        chk(ae_ofs == 16'hB2A1, "R3 ae order", ae_ofs, 16'hB2A1);
        chk(af_ofs == 16'hD4C3, "R3 af order", af_ofs, 16'hD4C3);
        reg_write(9'h055);
        chk(ae_ofs == 16'hB255, "R4 wrap", ae_ofs, 16'hB255);
        chk(af_ofs == 16'hD4C3, "R4 af kept", af_ofs, 16'hD4C3);
    endtask

    task automatic test_readback();
        logic [8:0] exp [5] = '{9'h055, 9'h0B2, 9'h0C3, 9'h0D4, 9'h055};
        for (int i = 0; i < 5; i++) begin
            reg_read();
            chk(rb_data == exp[i], "R5 readback", rb_data, exp[i]);
        end
    endtask

    task automatic test_mem_and_hold();
        @(negedge clk);
        mem_sel = 1'b1; wen_n = 1'b0; ren_n = 1'b0; din = 9'h0FF;
        #1;
        chk(mem_wr && mem_rd, "R2 both strobes", {mem_wr, mem_rd}, 2'b11);
        @(negedge clk);
        chk(ae_ofs == 16'hB255 && af_ofs == 16'hD4C3, "R2 offsets kept", ae_ofs, 16'hB255);
        mem_sel = 1'b0;
        #1;
        chk(!mem_wr && !mem_rd, "R10 strobes off", {mem_wr, mem_rd}, 0);
        @(negedge clk); idle();
        chk(ae_ofs == 16'hB255 && af_ofs == 16'hD4C3, "R9 no-op", ae_ofs, 16'hB255);
        reg_write(9'h066);
        chk(ae_ofs == 16'h6655, "R9 pointer held", ae_ofs, 16'h6655);
        shift_bit(1'b1); shift_bit(1'b0);
        chk(ae_ofs == 16'h6655 && af_ofs == 16'hD4C3, "R8 shift ignored", ae_ofs, 16'h6655);
        reg_write(9'h077);
        chk(af_ofs == 16'hD477, "R9 next step", af_ofs, 16'hD477);
    endtask

    task automatic test_mode_latch();
        do_reset(1'b0);
        load_mode = 1'b1;
        for (int i = 0; i < 32; i++) shift_bit(1'b1);
        chk(ae_ofs == 16'h0007 && af_ofs == 16'h003F, "R7 late mode ignored", ae_ofs, 16'h0007);
        reg_write(9'h0AA);
        chk(ae_ofs == 16'h00AA, "R7 parallel kept", ae_ofs, 16'h00AA);
    endtask

    task automatic test_serial();
        logic [31:0] pat = 32'h1234_ABCD;
        do_reset(1'b1);
        load_mode = 1'b0;
        for (int i = 0; i < 32; i++) shift_bit(pat[i]);
        chk(ae_ofs == 16'hABCD, "R6 ae serial", ae_ofs, 16'hABCD);
        chk(af_ofs == 16'h1234, "R6 af serial", af_ofs, 16'h1234);
        reg_write(9'h011);
        chk(ae_ofs == 16'hABCD && af_ofs == 16'h1234, "R8 par ignored", ae_ofs, 16'hABCD);
        reg_read();
        chk(rb_data == 9'h0CD, "R5 serial readback", rb_data, 9'h0CD);
        for (int i = 0; i < 32; i++) shift_bit(1'b0);
        chk(ae_ofs == 16'h0 && af_ofs == 16'h0, "R6 reshift", af_ofs, 0);
        mem_sel = 1'b0; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b1; sdin = 1'b1;
        @(negedge clk); idle();
        chk(ae_ofs == 16'h0, "R9 sen_n high holds", ae_ofs, 0);
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_par_write();
        test_readback();
        test_mem_and_hold();
        test_mode_latch();
        test_serial();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule